// File: doc/BRIEF.md
# PS/2 Line Bit-Bang Port

This block gives a host processor direct software control over the two wires of a PS/2 keyboard connector. It decodes one I/O address on an 8-bit processor bus. Behind that address sit three stored bits: a data-line level, a clock-line level and a drive enable. While the enable is set, the block drives the stored levels onto the two lines. While it is clear, both line drivers are off and external pull-up resistors hold the wires high. Software produces or receives PS/2 frames by writing and reading this one location in a loop. The block has no protocol engine.

A read of the address returns the physical levels present on the two wires, not the stored bits. The line inputs pass through a two-flop synchronizer, so what software sees is the level two clock edges old. Pad logic outside the block turns each output/enable pair into an open wire. The bus strobes are expected to be synchronous to the system clock.

Top module: `ps2_bitbang_port`

## Requirements
- R1: The port reacts only when the address equals 0xF4 and iorq_n is low. Any other address, or iorq_n high, leaves the stored bits unchanged and the read bus undriven.
- R2: dbus_oe is high exactly while the address matches, iorq_n is low and rd_n is low. At all other times it is low.
- R3: Reset leaves the stored data level at 1, the stored clock level at 1 and the enable at 0. Both line enables are therefore low.
- R4: A write stores bus bit 0 as the data level, bit 1 as the enable and bit 7 as the clock level. Bits 6 to 2 of the written value have no effect.
- R5: While the enable is 1, kbd_data_oe and kbd_clk_oe are both high. kbd_data_o carries the stored data level and kbd_clk_o carries the stored clock level.
- R6: While the enable is 0, kbd_data_oe and kbd_clk_oe are both low, which releases both lines.
- R7: Read data carries the synchronized data-line level on bit 0 and the synchronized clock-line level on bit 7. Bits 6 to 1 always read 0, and the stored bits are never returned.
- R8: A change on kbd_data_i or kbd_clk_i reaches the read data after exactly two rising clock edges.
- R9: A write is taken once, on the first clock edge at which the decoded write strobe is seen low. A strobe held low longer does not write again, even if the bus data changes, and the stored bits do not change between writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | Low byte of the I/O address |
| iorq_n | input | 1 | Active-low I/O request |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| dbus_wr | input | 8 | Data from the processor during a write |
| dbus_rd | output | 8 | Data returned to the processor |
| dbus_oe | output | 1 | Drive enable for dbus_rd |
| kbd_data_i | input | 1 | Level present on the PS/2 data wire |
| kbd_data_o | output | 1 | Level to drive on the PS/2 data wire |
| kbd_data_oe | output | 1 | Drive enable for the PS/2 data wire |
| kbd_clk_i | input | 1 | Level present on the PS/2 clock wire |
| kbd_clk_o | output | 1 | Level to drive on the PS/2 clock wire |
| kbd_clk_oe | output | 1 | Drive enable for the PS/2 clock wire |

## Verification
Two things can happen in the same cycle: a write that changes a driven line level, and the synchronizer sampling that line for a read. A write is the only way the block moves a wire. The bench therefore issues a write that releases the clock line from low to high, then holds a read strobe over the following edges. The read must show the old level with zero edges and with one edge after the write, and the new level after the second edge. The same edge counting is applied when an external device pulls a released line low. A held write strobe with the bus data changing partway through checks that only the first value is stored.

// File: rtl/ps2p_pkg.sv
package ps2p_pkg;

  localparam int BUS_W   = 8;
  localparam int BIT_DAT = 0;
  localparam int BIT_EN  = 1;
  localparam int BIT_CLK = 7;

  typedef struct packed {
    logic clk_lvl;
    logic en;
    logic dat_lvl;
  } ps2p_ctl_t;

  localparam ps2p_ctl_t CTL_RESET = '{clk_lvl: 1'b1, en: 1'b0, dat_lvl: 1'b1};

  function automatic ps2p_ctl_t unpack_ctl(input logic [BUS_W-1:0] word);
    ps2p_ctl_t c;
    c.dat_lvl = word[BIT_DAT];
    c.en      = word[BIT_EN];
    c.clk_lvl = word[BIT_CLK];
    return c;
  endfunction

  function automatic logic [BUS_W-1:0] pack_status(input logic dat, input logic clkl);
    logic [BUS_W-1:0] w;
    w          = '0;
    w[BIT_DAT] = dat;
    w[BIT_CLK] = clkl;
    return w;
  endfunction

endpackage

// File: rtl/ps2p_decode.sv
module ps2p_decode #(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  PORT_ADDR = 8'hF4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic              rd_sel,
  output logic              wr_evt
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(PORT_ADDR);

  logic hit;
  logic wr_sel;
  logic wr_seen_q;

  assign hit    = (io_addr == MATCH) && !iorq_n;
  assign rd_sel = hit && !rd_n;
  assign wr_sel = hit && !wr_n;

  // one write per strobe: act on the first edge the strobe is seen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_seen_q <= 1'b0;
    else        wr_seen_q <= wr_sel;
  end

  assign wr_evt = wr_sel && !wr_seen_q;
endmodule

// File: rtl/ps2p_ctl_reg.sv
module ps2p_ctl_reg
  import ps2p_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_evt,
  input  ps2p_ctl_t wr_val,
  output ps2p_ctl_t ctl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl <= CTL_RESET;
    else if (wr_evt) ctl <= wr_val;
  end
endmodule

// File: rtl/ps2p_sync.sv
module ps2p_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ps2p_readmux.sv
module ps2p_readmux
  import ps2p_pkg::*;
(
  input  logic             rd_sel,
  input  logic             dat_s,
  input  logic             clk_s,
  output logic [BUS_W-1:0] dbus_rd,
  output logic             dbus_oe
);
  assign dbus_oe = rd_sel;
  assign dbus_rd = rd_sel ? pack_status(dat_s, clk_s) : '0;
endmodule

// File: rtl/ps2_bitbang_port.sv
module ps2_bitbang_port
  import ps2p_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter logic [7:0] PORT_ADDR   = 8'hF4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [BUS_W-1:0]  dbus_wr,
  output logic [BUS_W-1:0]  dbus_rd,
  output logic              dbus_oe,
  input  logic              kbd_data_i,
  output logic              kbd_data_o,
  output logic              kbd_data_oe,
  input  logic              kbd_clk_i,
  output logic              kbd_clk_o,
  output logic              kbd_clk_oe
);
  localparam int NLINES = 2;

  logic      rd_sel;
  logic      wr_evt;
  ps2p_ctl_t ctl;
  ps2p_ctl_t wr_val;

  logic [NLINES-1:0] line_raw;
  logic [NLINES-1:0] line_s;

  logic unused_wr_bits;
  assign unused_wr_bits = ^dbus_wr;

  ps2p_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_decode (
    .clk    (clk),
    .rst_n  (rst_n),
    .io_addr(io_addr),
    .iorq_n (iorq_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .rd_sel (rd_sel),
    .wr_evt (wr_evt)
  );

  assign wr_val = unpack_ctl(dbus_wr);

  ps2p_ctl_reg u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_evt(wr_evt),
    .wr_val(wr_val),
    .ctl   (ctl)
  );

  assign kbd_data_o  = ctl.dat_lvl;
  assign kbd_clk_o   = ctl.clk_lvl;
  assign kbd_data_oe = ctl.en;
  assign kbd_clk_oe  = ctl.en;

  assign line_raw = {kbd_clk_i, kbd_data_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    ps2p_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (line_raw[g]),
      .q    (line_s[g])
    );
  end

  ps2p_readmux u_mux (
    .rd_sel (rd_sel),
    .dat_s  (line_s[0]),
    .clk_s  (line_s[1]),
    .dbus_rd(dbus_rd),
    .dbus_oe(dbus_oe)
  );
endmodule

// File: rtl/ps2_bitbang_port_chk.sv
module ps2_bitbang_port_chk #(
  parameter int         ADDR_W      = 8,
  parameter logic [7:0] PORT_ADDR   = 8'hF4,
  parameter int         SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              iorq_n,
  input logic              rd_n,
  input logic [7:0]        dbus_wr,
  input logic [7:0]        dbus_rd,
  input logic              dbus_oe,
  input logic              kbd_data_i,
  input logic              kbd_data_o,
  input logic              kbd_data_oe,
  input logic              kbd_clk_i,
  input logic              kbd_clk_o,
  input logic              kbd_clk_oe,
  input logic              wr_evt
);
  logic [1:0] live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         live <= 2'd0;
    else if (live != 3) live <= live + 2'd1;
  end

  a_r3_reset_vals: assert property (@(posedge clk)
    !rst_n |=> (kbd_data_o && kbd_clk_o && !kbd_data_oe && !kbd_clk_oe));

  a_r2_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr != ADDR_W'(PORT_ADDR) || iorq_n || rd_n) |-> !dbus_oe);

  a_r4_write_fields: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> (kbd_data_o == $past(dbus_wr[0]) && kbd_clk_o == $past(dbus_wr[7])
                && kbd_data_oe == $past(dbus_wr[1])));

  a_r9_hold_between_writes: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |=> ($stable(kbd_data_o) && $stable(kbd_clk_o) && $stable(kbd_data_oe)));

  a_r5_r6_enables_match: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_data_oe == kbd_clk_oe);

  a_r7_idle_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dbus_oe |-> (dbus_rd[6:1] == 6'd0));

  if (SYNC_STAGES == 2) begin : g_lat
    a_r8_two_edge_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (dbus_oe && live >= 2) |->
        (dbus_rd[0] == $past(kbd_data_i, 2) && dbus_rd[7] == $past(kbd_clk_i, 2)));
  end
endmodule

bind ps2_bitbang_port ps2_bitbang_port_chk #(
  .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_addr    (io_addr),
  .iorq_n     (iorq_n),
  .rd_n       (rd_n),
  .dbus_wr    (dbus_wr),
  .dbus_rd    (dbus_rd),
  .dbus_oe    (dbus_oe),
  .kbd_data_i (kbd_data_i),
  .kbd_data_o (kbd_data_o),
  .kbd_data_oe(kbd_data_oe),
  .kbd_clk_i  (kbd_clk_i),
  .kbd_clk_o  (kbd_clk_o),
  .kbd_clk_oe (kbd_clk_oe),
  .wr_evt     (wr_evt)
);

// File: tb/ps2_bitbang_port_bench.sv
`timescale 1ns/1ps
module ps2_bitbang_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] io_addr = 8'h00;
  logic       iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] dbus_wr = 8'h00;
  logic [7:0] dbus_rd;
  logic       dbus_oe;
  logic       dat_o, dat_oe, ck_o, ck_oe;
  logic       ext_dat_low = 1'b0, ext_ck_low = 1'b0;
  logic       dat_line, ck_line;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // wires with weak pull-ups, wired-AND with an external open-drain pull-down
  assign dat_line = (dat_oe ? dat_o : 1'b1) & ~ext_dat_low;
  assign ck_line  = (ck_oe  ? ck_o  : 1'b1) & ~ext_ck_low;

  ps2_bitbang_port u_ps2_bitbang_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .iorq_n(iorq_n),
    .rd_n(rd_n), .wr_n(wr_n), .dbus_wr(dbus_wr), .dbus_rd(dbus_rd),
    .dbus_oe(dbus_oe), .kbd_data_i(dat_line), .kbd_data_o(dat_o),
    .kbd_data_oe(dat_oe), .kbd_clk_i(ck_line), .kbd_clk_o(ck_o),
    .kbd_clk_oe(ck_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // outputs packed {oe_d, oe_c, data_o, clk_o}
  function automatic logic [7:0] lines();
    return {4'b0, dat_oe, ck_oe, dat_o, ck_o};
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [7:0] v, input logic rq_n);
    @(negedge clk);
    io_addr = a; iorq_n = rq_n; wr_n = 1'b0; dbus_wr = v;
    @(negedge clk);
    iorq_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] v, output logic oe);
    @(negedge clk);
    io_addr = a; iorq_n = 1'b0; rd_n = 1'b0;
    #1; v = dbus_rd; oe = dbus_oe;
    iorq_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v; logic oe;
    check("R3 reset line outputs", lines(), 8'h03);
    check("R6 released after reset", {6'b0, dat_oe, ck_oe}, 8'h00);
    bus_read(8'hF4, v, oe);
    check("R2 read drives bus", {7'b0, oe}, 8'h01);
    check("R7 pulled-up lines read 0x81", v, 8'h81);
  endtask

  task automatic t_enable_low();
    logic [7:0] v; logic oe;
    bus_write(8'hF4, 8'h02, 1'b0);
    check("R5 enabled, both levels low", lines(), 8'h0C);
    settle();
    bus_read(8'hF4, v, oe);
    check("R7 driven-low lines read 0x00", v, 8'h00);
  endtask

  task automatic t_unused_bits();
    logic [7:0] v; logic oe;
    bus_write(8'hF4, 8'h7F, 1'b0);
    check("R4 bits 6..2 ignored on write", lines(), 8'h0E);
    settle();
    bus_read(8'hF4, v, oe);
    check("R7 bits 6..1 read zero", v, 8'h01);
  endtask

  task automatic t_decode();
    logic [7:0] v; logic oe;
    bus_write(8'hF5, 8'h81, 1'b0);
    check("R1 other address no write", lines(), 8'h0E);
    bus_write(8'hF4, 8'h81, 1'b1);
    check("R1 iorq_n high no write", lines(), 8'h0E);
    bus_read(8'hF5, v, oe);
    check("R2 other address leaves bus off", {7'b0, oe}, 8'h00);
  endtask

  task automatic t_write_then_read();
    @(negedge clk);
    io_addr = 8'hF4; iorq_n = 1'b0; wr_n = 1'b0; dbus_wr = 8'h83;
    @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b0;
    #1;
    check("R8 zero edges after write", dbus_rd, 8'h01);
    @(negedge clk); #1;
    check("R8 one edge after write", dbus_rd, 8'h01);
    @(negedge clk); #1;
    check("R8 two edges after write", dbus_rd, 8'h81);
    iorq_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic t_release_and_force();
    logic [7:0] v; logic oe;
    bus_write(8'hF4, 8'h80, 1'b0);
    check("R6 disable releases lines", {6'b0, dat_oe, ck_oe}, 8'h00);
    settle();
    @(negedge clk);
    io_addr = 8'hF4; iorq_n = 1'b0; rd_n = 1'b0; ext_ck_low = 1'b1;
    #1;
    check("R8 forced clock, zero edges", dbus_rd, 8'h81);
    @(negedge clk); #1;
    check("R8 forced clock, one edge", dbus_rd, 8'h81);
    @(negedge clk); #1;
    check("R7 forced clock reads low", dbus_rd, 8'h01);
    iorq_n = 1'b1; rd_n = 1'b1;
    ext_dat_low = 1'b1;
    settle();
    bus_read(8'hF4, v, oe);
    check("R7 both forced low, stored bits not returned", v, 8'h00);
    ext_dat_low = 1'b0; ext_ck_low = 1'b0;
    settle();
  endtask

  task automatic t_held_strobe();
    @(negedge clk);
    io_addr = 8'hF4; iorq_n = 1'b0; wr_n = 1'b0; dbus_wr = 8'h83;
    @(negedge clk);
    dbus_wr = 8'h02;
    repeat (2) @(negedge clk);
    iorq_n = 1'b1; wr_n = 1'b1;
    check("R9 held strobe writes once", lines(), 8'h0F);
    repeat (2) @(negedge clk);
    check("R9 state stable without write", lines(), 8'h0F);
  endtask

  task automatic t_reset_again();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R3 mid-run reset restores idle", lines(), 8'h03);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_enable_low();
    t_unused_bits();
    t_decode();
    t_write_then_read();
    t_release_and_force();
    t_held_strobe();
    t_reset_again();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule